// File: doc/BRIEF.md
# Two-Phase Successive-Approximation Sequencer

This block is the digital sequencer for a 10-bit column converter whose search can be split into two phases. A coarse conversion resolves only the upper part of a sample. A later fine conversion takes a new sample, loads an externally supplied upper code into the DAC word, and searches only the low-order bits. For completeness, a full conversion runs the whole ten-step search from zero. Each conversion starts with a programmable sampling window. During that window the sample-enable output is high. After it, one comparator decision is taken per clock, from the most significant bit down.

An accumulator downstream feeds the fine phase. It averages several coarse results and returns the rounded upper code on the preload input. Because the fine search skips four decisions, it is shorter than a full conversion. The result is a registered word, qualified by a one-cycle done pulse, and it holds until the next done pulse. The result stream has no back-pressure: the consumer must take the word while done is high, or read it later while it holds. The start input is a plain request. It is accepted only when the sequencer is idle, and it has no ready response, so a request made while a conversion runs is lost.

Top module: `sar2p_ctrl_top`

## Requirements
- R1: With mode 2'b00 (full), the search starts from an all-zero word and resolves bits 9 down to 0. During each decision the word carries the trial bit. A comparator value of 1 means the input is at or above the DAC level, and it keeps the trial bit; 0 clears it. For an input code from 0 to 1023, the result equals that code.
- R2: The cycle after the accepting clock edge counts as cycle 1. Done is high in cycle H+N+1, where N is 10 for full mode, 5 for coarse mode and 6 for fine mode.
- R3: Sample-enable is high for exactly H cycles, starting in cycle 1. H is taken from sample_len_i at acceptance. A value of 0 is treated as 1, and later changes have no effect on the running conversion.
- R4: With mode 2'b01 (coarse), only bits 9 down to 5 are resolved. Bits 4..0 of the DAC word and of the result stay 0, so the result is the input code rounded down to a multiple of 32.
- R5: With mode 2'b10 (fine), bits 9..6 of the word are loaded from preload_i and held for the whole conversion, and bits 5 down to 0 are searched. The result is preload*64 plus the input minus preload*64, limited to the range 0..63.
- R6: In cycle H+1, the first decision cycle, the DAC word is the starting word with only the top trial bit added. That trial bit is bit 9 in full and coarse modes and bit 5 in fine mode.
- R7: A start pulse that arrives while a conversion or its done cycle is in progress is ignored. It causes no second conversion, and it changes neither the mode nor the sampling length in use.
- R8: Done is high for exactly one cycle per conversion. The result changes only at the edge that raises done, and it holds afterwards.
- R9: Mode 2'b11 behaves as full mode. The preload input has no effect outside fine mode.
- R10: While reset is asserted, and right after it, the DAC word, result, done and sample-enable are 0, and no conversion starts even if start is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, accepted only when idle |
| mode_i | input | 2 | 00 full, 01 coarse, 10 fine, 11 treated as full |
| preload_i | input | 4 | Upper code loaded into bits 9..6 in fine mode |
| cmp_i | input | 1 | Comparator decision for the current DAC word, 1 = input at or above |
| sample_len_i | input | 3 | Sampling window length H in clocks (0 treated as 1) |
| dac_o | output | 10 | DAC control word |
| sample_en_o | output | 1 | High during the sampling window |
| result_o | output | 10 | Converted code, updated with done |
| done_o | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The assertions rely on two properties of the inputs. The comparator decision must depend only on the present DAC word and on an input level that stays fixed for the whole conversion. It must also settle within the same cycle, because the sequencer latches it at the next edge. The bench meets both conditions by driving the comparator combinationally from a per-conversion input code compared against dac_o. It changes that code and all other inputs only on falling edges between conversions. The exception is the deliberate mid-conversion start, mode and length changes that test whether requests are ignored.

// File: rtl/sar2p_pkg.sv
package sar2p_pkg;

  typedef enum logic [1:0] {
    MODE_FULL   = 2'b00,
    MODE_COARSE = 2'b01,
    MODE_FINE   = 2'b10,
    MODE_RSVD   = 2'b11
  } conv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SAMP,
    ST_DEC,
    ST_DONE
  } seq_state_e;

endpackage

// File: rtl/sar2p_seq.sv
module sar2p_seq
  import sar2p_pkg::*;
#(
  parameter int DW     = 10,
  parameter int CW_NOM = 4,
  parameter int HW     = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  conv_mode_e             mode_i,
  input  logic [HW-1:0]          len_i,
  output seq_state_e             state_o,
  output conv_mode_e             mode_o,
  output logic [$clog2(DW)-1:0]  idx_o,
  output logic [$clog2(DW)-1:0]  first_idx_o,
  output logic                   accept_o,
  output logic                   samp_end_o,
  output logic                   dec_o,
  output logic                   dec_last_o
);
  localparam int CW = CW_NOM + 1;
  localparam int FB = DW - CW_NOM;
  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] IDX_MSB      = IW'(DW - 1);
  localparam logic [IW-1:0] IDX_FINE_TOP = IW'(FB - 1);
  localparam logic [IW-1:0] IDX_CRS_LAST = IW'(DW - CW);
  localparam logic [HW-1:0] CNT_ONE      = HW'(1);

  seq_state_e    state_q;
  conv_mode_e    mode_q;
  logic [HW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] last_idx;
  logic [HW-1:0] len_eff;

  assign len_eff     = (len_i == '0) ? CNT_ONE : len_i;
  assign first_idx_o = (mode_q == MODE_FINE) ? IDX_FINE_TOP : IDX_MSB;
  assign last_idx    = (mode_q == MODE_COARSE) ? IDX_CRS_LAST : '0;

  assign accept_o   = (state_q == ST_IDLE) && start_i;
  assign samp_end_o = (state_q == ST_SAMP) && (cnt_q == CNT_ONE);
  assign dec_o      = (state_q == ST_DEC);
  assign dec_last_o = dec_o && (idx_q == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_FULL;
      cnt_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= mode_i;
          cnt_q   <= len_eff;
          state_q <= ST_SAMP;
        end
        ST_SAMP: begin
          if (cnt_q == CNT_ONE) begin
            idx_q   <= first_idx_o;
            state_q <= ST_DEC;
          end else begin
            cnt_q <= cnt_q - CNT_ONE;
          end
        end
        ST_DEC: begin
          if (idx_q == last_idx) state_q <= ST_DONE;
          else                   idx_q   <= idx_q - 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign mode_o  = mode_q;
  assign idx_o   = idx_q;
endmodule

// File: rtl/sar2p_word.sv
module sar2p_word #(
  parameter int DW     = 10,
  parameter int CW_NOM = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept_i,
  input  logic                   fine_i,
  input  logic [CW_NOM-1:0]      preload_i,
  input  logic                   samp_end_i,
  input  logic [$clog2(DW)-1:0]  first_idx_i,
  input  logic                   dec_i,
  input  logic                   dec_last_i,
  input  logic [$clog2(DW)-1:0]  idx_i,
  input  logic                   cmp_i,
  output logic [DW-1:0]          word_o,
  output logic [DW-1:0]          word_nxt_o
);
  localparam int FB = DW - CW_NOM;

  logic [DW-1:0] word_q;
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = word_q;
    if (accept_i) begin
      nxt = fine_i ? {preload_i, {FB{1'b0}}} : '0;
    end else if (samp_end_i) begin
      nxt[first_idx_i] = 1'b1;
    end else if (dec_i) begin
      nxt[idx_i] = cmp_i;
      if (!dec_last_i) nxt[idx_i - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= nxt;
  end

  assign word_o     = word_q;
  assign word_nxt_o = nxt;
endmodule

// File: rtl/sar2p_ctrl_top.sv
module sar2p_ctrl_top
  import sar2p_pkg::*;
#(
  parameter int DW     = 10,
  parameter int CW_NOM = 4,
  parameter int HW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [CW_NOM-1:0] preload_i,
  input  logic              cmp_i,
  input  logic [HW-1:0]     sample_len_i,
  output logic [DW-1:0]     dac_o,
  output logic              sample_en_o,
  output logic [DW-1:0]     result_o,
  output logic              done_o
);
  localparam int IW = $clog2(DW);

  conv_mode_e    mode_dec;
  seq_state_e    seq_state;
  conv_mode_e    seq_mode;
  logic [IW-1:0] idx;
  logic [IW-1:0] first_idx;
  logic          accept;
  logic          samp_end;
  logic          dec;
  logic          dec_last;
  logic [DW-1:0] word_nxt;
  logic [DW-1:0] result_q;

  assign mode_dec = (mode_i == 2'b11) ? MODE_FULL : conv_mode_e'(mode_i);

  sar2p_seq #(.DW(DW), .CW_NOM(CW_NOM), .HW(HW)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_dec),
    .len_i       (sample_len_i),
    .state_o     (seq_state),
    .mode_o      (seq_mode),
    .idx_o       (idx),
    .first_idx_o (first_idx),
    .accept_o    (accept),
    .samp_end_o  (samp_end),
    .dec_o       (dec),
    .dec_last_o  (dec_last)
  );

  sar2p_word #(.DW(DW), .CW_NOM(CW_NOM)) word_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept_i    (accept),
    .fine_i      (mode_dec == MODE_FINE),
    .preload_i   (preload_i),
    .samp_end_i  (samp_end),
    .first_idx_i (first_idx),
    .dec_i       (dec),
    .dec_last_i  (dec_last),
    .idx_i       (idx),
    .cmp_i       (cmp_i),
    .word_o      (dac_o),
    .word_nxt_o  (word_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        result_q <= '0;
    else if (dec_last) result_q <= word_nxt;
  end

  assign result_o    = result_q;
  assign done_o      = (seq_state == ST_DONE);
  assign sample_en_o = (seq_state == ST_SAMP);
endmodule

// File: rtl/sar2p_chk.sv
module sar2p_chk
  import sar2p_pkg::*;
#(
  parameter int DW     = 10,
  parameter int CW_NOM = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done_o,
  input logic          sample_en_o,
  input logic [DW-1:0] dac_o,
  input logic [DW-1:0] result_o,
  input seq_state_e    state_i,
  input conv_mode_e    mode_i
);
  localparam int CW = CW_NOM + 1;
  localparam int FB = DW - CW_NOM;

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);

  a_r2_decide_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !$past(sample_en_o));

  a_r5_fine_high_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_FINE && state_i != ST_IDLE && $past(state_i) != ST_IDLE)
      |-> $stable(dac_o[DW-1:FB]));

  a_r4_coarse_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_COARSE && state_i != ST_IDLE) |-> (dac_o[DW-CW-1:0] == '0));

  a_r7_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (state_i != ST_IDLE && $past(state_i) != ST_IDLE) |-> $stable(mode_i));
endmodule

bind sar2p_ctrl_top sar2p_chk #(.DW(DW), .CW_NOM(CW_NOM)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .sample_en_o (sample_en_o),
  .dac_o       (dac_o),
  .result_o    (result_o),
  .state_i     (seq_state),
  .mode_i      (seq_mode)
);

// File: tb/sar2p_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module sar2p_ctrl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [3:0] preload_i = '0;
  logic       cmp_i;
  logic [2:0] sample_len_i = 3'd1;
  logic [9:0] dac_o;
  logic       sample_en_o;
  logic [9:0] result_o;
  logic       done_o;

  int vin = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign cmp_i = (vin >= int'(dac_o));

  sar2p_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .preload_i(preload_i), .cmp_i(cmp_i), .sample_len_i(sample_len_i),
    .dac_o(dac_o), .sample_en_o(sample_en_o), .result_o(result_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one conversion and checks latency, sampling window, first trial word,
  // result and done width. inject: issue a start with other settings mid-run.
  task automatic run_conv(input logic [1:0] m, input int pre, input int v, input int len,
                          input int n_bits, input int exp_first, input int exp_res,
                          input bit inject, input string req);
    int len_eff, cyc, samp_cnt, first_word;
    len_eff = (len == 0) ? 1 : len;
    @(negedge clk);
    vin = v; mode_i = m; preload_i = 4'(pre); sample_len_i = 3'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1; samp_cnt = 0; first_word = -1;
    forever begin
      if (sample_en_o) samp_cnt++;
      if (cyc == len_eff + 1) first_word = int'(dac_o);
      if (done_o || cyc > 200) break;
      if (inject && cyc == 2) begin
        start_i = 1'b1; mode_i = 2'b01; sample_len_i = 3'd7; preload_i = 4'd3;
      end
      if (inject && cyc == 3) start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    chk(cyc == len_eff + n_bits + 1, {req, " R2 done cycle"}, cyc, len_eff + n_bits + 1);
    chk(samp_cnt == len_eff, {req, " R3 sample window"}, samp_cnt, len_eff);
    chk(first_word == exp_first, {req, " R6 first trial word"}, first_word, exp_first);
    chk(int'(result_o) == exp_res, {req, " result"}, int'(result_o), exp_res);
    @(negedge clk);
    chk(!done_o, {req, " R8 done one cycle"}, int'(done_o), 0);
  endtask

  function automatic int fine_exp(input int pre, input int v);
    int low;
    low = v - pre * 64;
    if (low < 0) low = 0;
    if (low > 63) low = 63;
    return pre * 64 + low;
  endfunction

  task automatic t_reset();
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; start_i = 1'b0;
    chk(dac_o == 0 && result_o == 0, "R10 reset word/result", int'(dac_o) + int'(result_o), 0);
    chk(!done_o && !sample_en_o, "R10 reset done/sample", int'(done_o) + int'(sample_en_o), 0);
    repeat (3) @(negedge clk);
    chk(!sample_en_o && !done_o, "R10 no conversion after reset", int'(sample_en_o), 0);
  endtask

  task automatic t_full();
    run_conv(2'b00, 0, 517, 1, 10, 512, 517, 1'b0, "R1 full 517");
    run_conv(2'b00, 0, 0, 3, 10, 512, 0, 1'b0, "R1 full 0");
    run_conv(2'b00, 0, 1023, 7, 10, 512, 1023, 1'b0, "R1 full 1023");
    run_conv(2'b00, 0, 341, 5, 10, 512, 341, 1'b0, "R1 full 341");
  endtask

  task automatic t_coarse();
    run_conv(2'b01, 0, 517, 2, 5, 512, 512, 1'b0, "R4 coarse 517");
    run_conv(2'b01, 0, 1023, 4, 5, 512, 992, 1'b0, "R4 coarse 1023");
    run_conv(2'b01, 0, 95, 1, 5, 512, 64, 1'b0, "R4 coarse 95");
  endtask

  task automatic t_fine();
    run_conv(2'b10, 8, 517, 1, 6, 8 * 64 + 32, fine_exp(8, 517), 1'b0, "R5 fine inside");
    run_conv(2'b10, 8, 400, 3, 6, 8 * 64 + 32, fine_exp(8, 400), 1'b0, "R5 fine below");
    run_conv(2'b10, 8, 900, 2, 6, 8 * 64 + 32, fine_exp(8, 900), 1'b0, "R5 fine above");
    run_conv(2'b10, 15, 1000, 6, 6, 15 * 64 + 32, fine_exp(15, 1000), 1'b0, "R5 fine top");
  endtask

  task automatic t_busy_ignore();
    run_conv(2'b00, 0, 700, 2, 10, 512, 700, 1'b1, "R7 start while busy");
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (sample_en_o || done_o) break;
    end
    chk(!sample_en_o && !done_o, "R7 no second conversion", int'(sample_en_o), 0);
  endtask

  task automatic t_len_zero();
    run_conv(2'b00, 0, 200, 0, 10, 512, 200, 1'b0, "R3 length zero");
  endtask

  task automatic t_rsvd_preload();
    run_conv(2'b11, 5, 333, 2, 10, 512, 333, 1'b0, "R9 mode 11 as full");
    run_conv(2'b00, 15, 100, 1, 10, 512, 100, 1'b0, "R9 preload ignored full");
    run_conv(2'b01, 15, 100, 1, 5, 512, 96, 1'b0, "R9 preload ignored coarse");
  endtask

  task automatic t_hold();
    run_conv(2'b00, 0, 611, 1, 10, 512, 611, 1'b0, "R8 hold setup");
    vin = 5;
    repeat (6) @(negedge clk);
    chk(result_o == 10'd611, "R8 result held", int'(result_o), 611);
  endtask

  initial begin
    t_reset();
    t_full();
    t_coarse();
    t_fine();
    t_busy_ignore();
    t_len_zero();
    t_rsvd_preload();
    t_hold();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule